// File: doc/BRIEF.md
# Branch Clock Enable Controller

This block decides, on every cycle, whether one clock branch of a larger chip runs. A five-bit control word, written and read through a plain register port, picks the conditions. A run bit turns the branch off outright. An automatic-mode bit chooses between two behaviours. With automatic mode off, the branch follows only the run bit and the divider pulse. With automatic mode on, two more qualifiers can apply: a wake state and an external select strobe from the module the branch feeds.

The wake state is a sticky flag held inside the block. A rising edge on the wakeup input sets it. A power-mode write carrying the value 2'b11 clears it. An enable pulse from an optional fractional divider also qualifies the output; tie that input to 1 when no divider is attached.

The block drives the enable out directly. It can also copy the enable onto a status output. A latch that is transparent while the clock is low holds the enable for the high phase, and the gated clock is the clock ANDed with that latch. The gated clock therefore cannot glitch.

Top module: `branch_clk_enable`

## Requirements
- R1: When ctrl bit 0 (run) is 0, clk_en is 0 whatever the other bits and inputs hold.
- R2: When ctrl bit 1 (auto) is 0, ctrl bits 2 and 3 have no effect, and clk_en equals run AND frac_en.
- R3: The wake state is cleared in the cycle after a power-mode write (pm_wr=1) with pm_mode=2'b11. If a wakeup rising edge arrives in the same cycle, the clear wins.
- R4: While ctrl bit 2 (wake enable) is 1, a wakeup rising edge (0 in the previous cycle, 1 in this one) sets the wake state from the next cycle on. While bit 2 is 0, a wakeup edge leaves the wake state unchanged.
- R5: With auto=1, the wake state qualifies the enable when bit 2 is 1, and ext_en qualifies it when bit 3 (external enable) is 1. clk_en = run & frac_en & (bit2 ? wake : 1) & (bit3 ? ext_en : 1).
- R6: en_status equals clk_en when ctrl bit 4 (enable-out) is 1, and is 0 otherwise.
- R7: After reset the control word reads 5'b00111, and the wake state is 1.
- R8: A register write loads reg_wdata[4:0] into the control word. Bits 31:5 of the write are discarded, and they read back as 0.
- R9: While clk is high, gclk equals the enable value that was present at the end of the preceding low phase. While clk is low, gclk is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data, zero above bit 4 |
| wakeup | input | 1 | Wakeup event level; its rising edge sets the wake state |
| pm_wr | input | 1 | Power-mode write strobe |
| pm_mode | input | 2 | Power-mode value; 2'b11 clears the wake state |
| ext_en | input | 1 | Select strobe from the target module |
| frac_en | input | 1 | Divider enable pulse, tie to 1 if unused |
| clk_en | output | 1 | Branch clock enable |
| en_status | output | 1 | Mirrored enable status, gated by ctrl bit 4 |
| gclk | output | 1 | Glitch-free gated branch clock |

## Verification
A wrong wake state stays hidden until the control word makes it matter. It shows on clk_en one cycle after the event that corrupted it, but only while auto and wake enable are both 1. The sweep therefore prepares each wake value first, then applies every control word, every ext_en level and every frac_en level. A wrong control bit shows at once on reg_rdata and also masks or unmasks clk_en. The latch is checked during each high phase, where a wrong enable shows on gclk in the very next cycle.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int CTRL_W = 5;
  localparam int BIT_RUN  = 0;
  localparam int BIT_AUTO = 1;
  localparam int BIT_WAKE = 2;
  localparam int BIT_EXT  = 3;
  localparam int BIT_EOUT = 4;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 5'b00111;
  localparam logic [1:0] PM_SLEEP = 2'b11;

  typedef struct packed {
    logic eout;
    logic ext;
    logic wake;
    logic auto_m;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/bce_ctrl_reg.sv
module bce_ctrl_reg
  import bce_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= CTRL_RESET;
    else if (wr)
      ctrl_q <= wdata[CTRL_W-1:0];
  end

  assign ctrl  = ctrl_t'(ctrl_q);
  assign rdata = {{PAD_W{1'b0}}, ctrl_q};
endmodule

// File: rtl/bce_wake_track.sv
module bce_wake_track
  import bce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wake_arm,
  input  logic       wakeup,
  input  logic       pm_wr,
  input  logic [1:0] pm_mode,
  output logic       wake_state
);
  logic wake_prev;
  logic rise;
  logic clear;

  assign rise  = wakeup & ~wake_prev & wake_arm;
  assign clear = pm_wr & (pm_mode == PM_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_prev  <= 1'b0;
      wake_state <= 1'b1;
    end else begin
      wake_prev <= wakeup;
      if (clear)
        wake_state <= 1'b0;
      else if (rise)
        wake_state <= 1'b1;
    end
  end
endmodule

// File: rtl/bce_gate.sv
module bce_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk)
      en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/branch_clk_enable.sv
module branch_clk_enable
  import bce_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wakeup,
  input  logic              pm_wr,
  input  logic [1:0]        pm_mode,
  input  logic              ext_en,
  input  logic              frac_en,
  output logic              clk_en,
  output logic              en_status,
  output logic              gclk
);
  ctrl_t ctrl;
  logic  wake_state;
  logic  wake_term;
  logic  ext_term;
  logic  qual;

  bce_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  bce_wake_track u_wake (
    .clk        (clk),
    .rst        (rst),
    .wake_arm   (ctrl.wake),
    .wakeup     (wakeup),
    .pm_wr      (pm_wr),
    .pm_mode    (pm_mode),
    .wake_state (wake_state)
  );

  assign wake_term = ctrl.wake ? wake_state : 1'b1;
  assign ext_term  = ctrl.ext  ? ext_en     : 1'b1;
  assign qual      = ctrl.auto_m ? (wake_term & ext_term) : 1'b1;
  assign clk_en    = ctrl.run & frac_en & qual;
  assign en_status = ctrl.eout & clk_en;

  bce_gate u_gate (
    .clk  (clk),
    .en   (clk_en),
    .gclk (gclk)
  );
endmodule

// File: rtl/branch_clk_enable_chk.sv
module branch_clk_enable_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              wakeup,
  input logic              pm_wr,
  input logic [1:0]        pm_mode,
  input logic              frac_en,
  input logic              clk_en,
  input logic              en_status,
  input logic              wake_state
);
  p_run_off_r1: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[0] |-> !clk_en);

  p_manual_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[1:0] == 2'b01) |-> (clk_en == frac_en));

  p_sleep_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (pm_wr && pm_mode == 2'b11) |=> !wake_state);

  p_wake_set_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(wakeup) && reg_rdata[2] && !(pm_wr && pm_mode == 2'b11)) |=> wake_state);

  p_eout_r6: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[4] |-> !en_status);

  p_reset_val_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_rdata[4:0] == 5'b00111 && wake_state));

  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:5] == '0);
endmodule

bind branch_clk_enable branch_clk_enable_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rdata  (reg_rdata),
  .wakeup     (wakeup),
  .pm_wr      (pm_wr),
  .pm_mode    (pm_mode),
  .frac_en    (frac_en),
  .clk_en     (clk_en),
  .en_status  (en_status),
  .wake_state (wake_state)
);

// File: tb/branch_clk_enable_test.sv
module branch_clk_enable_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wakeup = 1'b0;
  logic        pm_wr = 1'b0;
  logic [1:0]  pm_mode = 2'b00;
  logic        ext_en = 1'b0;
  logic        frac_en = 1'b1;
  logic        clk_en;
  logic        en_status;
  logic        gclk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_clk_enable uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wakeup(wakeup), .pm_wr(pm_wr), .pm_mode(pm_mode),
    .ext_en(ext_en), .frac_en(frac_en), .clk_en(clk_en),
    .en_status(en_status), .gclk(gclk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pm_sleep();
    @(negedge clk); pm_wr = 1'b1; pm_mode = 2'b11;
    @(negedge clk); pm_wr = 1'b0; pm_mode = 2'b00;
  endtask

  task automatic wake_pulse();
    @(negedge clk); wakeup = 1'b0;
    @(negedge clk); wakeup = 1'b1;
    @(negedge clk); wakeup = 1'b0;
  endtask

  function automatic logic exp_en(input logic [4:0] c, input logic ws,
                                  input logic x, input logic f);
    logic q;
    q = c[1] ? ((c[2] ? ws : 1'b1) & (c[3] ? x : 1'b1)) : 1'b1;
    return c[0] & f & q;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    // R7 reset state
    check("R7 ctrl reset", reg_rdata, 32'h7);
    check("R7 enable after reset", {31'b0, clk_en}, 32'h1);
    check("R9 gclk high phase", {31'b0, gclk}, 32'h1);
    #4;
    check("R9 gclk low phase", {31'b0, gclk}, 32'h0);

    // Sweep: every control word, both wake states, ext/frac combos
    for (int ws = 0; ws < 2; ws++) begin
      for (int c = 0; c < 32; c++) begin
        wr_ctrl(32'h0000_0004);
        if (ws == 1) wake_pulse(); else pm_sleep();
        wr_ctrl({27'h7FF_FFFF, c[4:0]});   // R8 upper bits set
        @(posedge clk); #2;
        check("R8 readback", reg_rdata, {27'b0, c[4:0]});
        for (int k = 0; k < 4; k++) begin
          logic e;
          @(negedge clk); ext_en = k[0]; frac_en = k[1];
          @(posedge clk); #2;
          e = exp_en(c[4:0], ws[0], k[0], k[1]);
          // R1 R2 R5 combined enable
          check(c[0] ? (c[1] ? "R5 enable" : "R2 enable") : "R1 enable", {31'b0, clk_en}, {31'b0, e});
          check("R6 status", {31'b0, en_status}, {31'b0, e & c[4]});
          check("R9 gclk", {31'b0, gclk}, {31'b0, e});
        end
        @(negedge clk); ext_en = 1'b0; frac_en = 1'b1;
      end
    end

    // R4: edge ignored while wake enable is 0
    wr_ctrl(32'h0000_0004);
    pm_sleep();
    wr_ctrl(32'h0000_0003);
    wake_pulse();
    wr_ctrl(32'h0000_0007);
    @(posedge clk); #2;
    check("R4 edge ignored when disarmed", {31'b0, clk_en}, 32'h0);
    wake_pulse();
    @(posedge clk); #2;
    check("R4 edge sets when armed", {31'b0, clk_en}, 32'h1);

    // R3: clear wins over a same-cycle edge
    pm_sleep();
    @(negedge clk); wakeup = 1'b0;
    @(negedge clk); wakeup = 1'b1; pm_wr = 1'b1; pm_mode = 2'b11;
    @(negedge clk); wakeup = 1'b0; pm_wr = 1'b0; pm_mode = 2'b00;
    @(posedge clk); #2;
    check("R3 clear beats edge", {31'b0, clk_en}, 32'h0);
    // R3: other mode values do not clear
    wake_pulse();
    @(negedge clk); pm_wr = 1'b1; pm_mode = 2'b10;
    @(negedge clk); pm_wr = 1'b0; pm_mode = 2'b00;
    @(posedge clk); #2;
    check("R3 mode 10 keeps wake", {31'b0, clk_en}, 32'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule